// File: doc/BRIEF.md
# Serial memory controller status and interrupt unit

This unit collects the event pulses that a serial memory transfer engine raises and holds them as sticky status flags. A small register bus lets software read the flags, which clears them, and program an interrupt mask through separate set and clear registers. A single level interrupt request is raised while any flag that is held is also enabled in the mask.

The unit also follows command completion. A command is complete only once both the instruction-end event and the chip-select-rise event have been seen. The two may arrive in either order, and a status read may fall between them. When the second one arrives, the unit gives a one-cycle completion pulse.

The register bus has four word registers, picked by `reg_addr_i`: 0 status, 1 mask set, 2 mask clear, 3 mask readback. Read data is registered and is valid in the cycle after the read strobe.

Top module: `sm_irq_ctrl`

## Requirements
- R1: After reset the status event flags, the mask, `reg_rdata_o`, `irq_o` and `cmd_done_o` are all zero.
- R2: A pulse on `evt_i[k]` sets a sticky status flag. The flags sit at these status word bits: k=0 receive full at bit 0, k=1 transmit empty at bit 1, k=2 transmitter idle at bit 2, k=3 overrun at bit 3, k=4 chip-select rise at bit 8, k=5 chip-select fall at bit 9, k=6 instruction end at bit 10.
- R3: A read of address 0 returns the status word in the next cycle and clears every event flag.
- R4: An event that arrives in the same cycle as a status read is not part of that read's data, and it stays set for the next read.
- R5: Status bit 24 follows `en_lvl_i` live and is not cleared by a read.
- R6: A write to address 1 sets each mask bit whose write data bit is 1. Data bits that are 0 leave the mask unchanged.
- R7: A write to address 2 clears each mask bit whose write data bit is 1. Data bits that are 0 leave the mask unchanged.
- R8: Address 3 reads back the mask in the status bit layout. Bits outside that layout read as 0. Addresses 1 and 2 read as zero.
- R9: `irq_o` is high exactly when the current status word ANDed with the mask is nonzero.
- R10: Writes to address 0 and address 3 change neither the flags nor the mask.
- R11: `cmd_done_o` pulses for one cycle, in the cycle after the later of instruction end and chip-select rise has arrived. The two are counted since the previous pulse, in either order, with status reads allowed in between.
- R12: If instruction end and chip-select rise arrive in the same cycle, `cmd_done_o` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Single-cycle event pulses, indices as in R2 |
| en_lvl_i | input | 1 | Controller-enabled level |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Level interrupt request |
| cmd_done_o | output | 1 | Command completion pulse |

## Verification
The bench builds the unit with the default values: a 32-bit data word and a 2-bit address. With these, all four registers can be reached, along with every flag position up to bit 24 and the unused upper bits that must read as zero. Directed tasks cover each event on its own, a read that collides with an event, masking with single bits and with the whole layout, and both arrival orders of the completion pair, including the case where the two arrive together.

// File: rtl/sm_irq_pkg.sv
package sm_irq_pkg;
  localparam int unsigned N_EVT  = 7;
  localparam int unsigned N_SRC  = N_EVT + 1;
  localparam int unsigned STAT_W = 25;

  localparam int unsigned EV_CSR  = 4;
  localparam int unsigned EV_IEND = 6;

  // status word bit for each source, last entry is the enabled level
  localparam int unsigned SRC_POS [N_SRC] = '{0, 1, 2, 3, 8, 9, 10, 24};

  function automatic logic [STAT_W-1:0] src_to_word(input logic [N_SRC-1:0] s);
    logic [STAT_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_SRC; i++) w[SRC_POS[i]] = s[i];
    return w;
  endfunction

  function automatic logic [N_SRC-1:0] word_to_src(input logic [STAT_W-1:0] w);
    logic [N_SRC-1:0] s;
    for (int i = 0; i < N_SRC; i++) s[i] = w[SRC_POS[i]];
    return s;
  endfunction
endpackage

// File: rtl/sm_evt_flags.sv
module sm_evt_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (clr_i) flag_q <= evt_i[i];  // keep event that collides with read
      else            flag_q <= flag_q | evt_i[i];
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/sm_irq_mask.sv
module sm_irq_mask #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (set_en_i) mask_q <= mask_q | bits_i;
    else if (clr_en_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/sm_cmd_track.sv
module sm_cmd_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iend_i,
  input  logic csr_i,
  output logic done_o
);
  logic seen_iend_q, seen_csr_q, done_q;
  logic iend_n, csr_n, both;

  assign iend_n = seen_iend_q | iend_i;
  assign csr_n  = seen_csr_q | csr_i;
  assign both   = iend_n & csr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_iend_q <= 1'b0;
      seen_csr_q  <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      seen_iend_q <= iend_n & ~both;
      seen_csr_q  <= csr_n & ~both;
      done_q      <= both;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/sm_irq_ctrl.sv
module sm_irq_ctrl
  import sm_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              en_lvl_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              cmd_done_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  logic [N_EVT-1:0]  flags_q;
  logic [N_SRC-1:0]  mask_q;
  logic [N_SRC-1:0]  src_now;
  logic [N_SRC-1:0]  wr_bits;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              stat_rd;
  logic              unused_wdata;

  assign stat_rd = reg_rd_i && (reg_addr_i == A_STAT);
  assign wr_bits = word_to_src(reg_wdata_i[STAT_W-1:0]);
  assign unused_wdata = ^reg_wdata_i;

  sm_evt_flags #(.N(N_EVT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (stat_rd),
    .flags_o (flags_q)
  );

  sm_irq_mask #(.N(N_SRC)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (reg_wr_i && (reg_addr_i == A_SET)),
    .clr_en_i (reg_wr_i && (reg_addr_i == A_CLR)),
    .bits_i   (wr_bits),
    .mask_o   (mask_q)
  );

  sm_cmd_track u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .iend_i (evt_i[EV_IEND]),
    .csr_i  (evt_i[EV_CSR]),
    .done_o (cmd_done_o)
  );

  assign src_now = {en_lvl_i, flags_q};

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_STAT:  rd_mux = {{PAD_W{1'b0}}, src_to_word(src_now)};
      A_MASK:  rd_mux = {{PAD_W{1'b0}}, src_to_word(mask_q)};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |(src_now & mask_q);
endmodule

module sm_irq_ctrl_chk
  import sm_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_EVT-1:0]  evt_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [N_EVT-1:0]  flags_i,
  input logic [N_SRC-1:0]  mask_i,
  input logic              irq_o
);
  logic [N_SRC-1:0] wsrc;
  assign wsrc = word_to_src(reg_wdata_i[STAT_W-1:0]);

  // R2 and R4: every pulsed event is held afterwards, read or not
  a_r2_evt_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_i & $past(evt_i)) == $past(evt_i)));

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_W'(0) && evt_i == '0) |=> (flags_i == '0));

  a_r6_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(1)) |=> ((mask_i & $past(wsrc)) == $past(wsrc)));

  a_r7_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(2)) |=> ((mask_i & $past(wsrc)) == '0));

  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  a_r10_stat_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(0) && !reg_rd_i && evt_i == '0)
      |=> ($stable(flags_i) && $stable(mask_i)));
endmodule

bind sm_irq_ctrl sm_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .flags_i     (flags_q),
  .mask_i      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/tb_sm_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sm_irq_ctrl;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [31:0] FULL = 32'h0100_070F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    evt = '0;
  logic          en_lvl = 1'b0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, done;
  int            total = 0, bad = 0;
  bit            finished = 0;

  always #2.5 clk = ~clk;

  sm_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .en_lvl_i(en_lvl),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .cmd_done_o(done)
  );

  // status word bit of each event index
  function automatic logic [31:0] ev_bit(input int k);
    int pos [7] = '{0, 1, 2, 3, 8, 9, 10};
    return 32'h1 << pos[k];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    step();
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt = e;
    step();
    evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 done", {31'b0, done}, 0);
    bus_rd(0, d); chk("R1 status", d, 0);
    bus_rd(3, d); chk("R1 mask", d, 0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    for (int k = 0; k < 7; k++) begin
      pulse(7'h1 << k);
      bus_rd(0, d); chk("R2 flag pos", d, ev_bit(k));
      bus_rd(0, d); chk("R3 cleared", d, 0);
    end
    pulse(7'h09);
    bus_rd(0, d); chk("R2 two flags", d, 32'h9);
  endtask

  task automatic t_live_en();
    logic [31:0] d;
    en_lvl = 1'b1;
    bus_rd(0, d); chk("R5 en bit", d, 32'h0100_0000);
    bus_rd(0, d); chk("R5 en kept", d, 32'h0100_0000);
    en_lvl = 1'b0;
    bus_rd(0, d); chk("R5 en low", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_wr(1, 32'h0000_0703);
    bus_rd(3, d); chk("R6 set", d, 32'h703);
    bus_wr(1, 32'h0000_0000);
    bus_rd(3, d); chk("R6 zeros keep", d, 32'h703);
    bus_wr(1, 32'hFFFF_FFFF);
    bus_rd(3, d); chk("R8 layout only", d, FULL);
    bus_wr(2, 32'h0000_0002);
    bus_rd(3, d); chk("R7 clr one", d, FULL & ~32'h2);
    bus_wr(2, 32'h0);
    bus_rd(3, d); chk("R7 zeros keep", d, FULL & ~32'h2);
    bus_rd(1, d); chk("R8 set reads 0", d, 0);
    bus_rd(2, d); chk("R8 clr reads 0", d, 0);
    bus_wr(2, 32'hFFFF_FFFF);
    bus_rd(3, d); chk("R7 clr all", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_wr(1, 32'h1);
    pulse(7'h02);
    chk("R9 unmasked flag", {31'b0, irq}, 0);
    pulse(7'h01);
    chk("R9 masked flag", {31'b0, irq}, 1);
    bus_rd(0, d); chk("R3 read data", d, 32'h3);
    chk("R9 after clear", {31'b0, irq}, 0);
    en_lvl = 1'b1;
    bus_wr(1, 32'h0100_0000);
    chk("R9 en level", {31'b0, irq}, 1);
    en_lvl = 1'b0; #1;
    chk("R9 en drop", {31'b0, irq}, 0);
    bus_wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    bus_wr(1, 32'h8);
    evt = 7'h08; rd = 1'b1; addr = 0;
    step();
    evt = '0; rd = 1'b0;
    chk("R4 not in read", rdata, 0);
    chk("R4 irq held", {31'b0, irq}, 1);
    bus_rd(0, d); chk("R4 kept", d, 32'h8);
    bus_wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_wr_ignore();
    logic [31:0] d;
    pulse(7'h02);
    bus_wr(0, 32'hFFFF_FFFF);
    bus_wr(3, 32'hFFFF_FFFF);
    bus_rd(3, d); chk("R10 mask kept", d, 0);
    bus_rd(0, d); chk("R10 status kept", d, 32'h2);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    pulse(7'h40);
    chk("R11 iend alone", {31'b0, done}, 0);
    bus_rd(0, d);
    chk("R11 still idle", {31'b0, done}, 0);
    pulse(7'h10);
    chk("R11 done csr last", {31'b0, done}, 1);
    step();
    chk("R11 one cycle", {31'b0, done}, 0);
    pulse(7'h10);
    chk("R11 csr alone", {31'b0, done}, 0);
    pulse(7'h40);
    chk("R11 done iend last", {31'b0, done}, 1);
    step();
    chk("R11 one cycle b", {31'b0, done}, 0);
    pulse(7'h50);
    chk("R12 same cycle", {31'b0, done}, 1);
    step();
    chk("R12 one cycle", {31'b0, done}, 0);
    bus_rd(0, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_flags();
    t_live_en();
    t_mask();
    t_irq();
    t_collide();
    t_wr_ignore();
    t_cmd();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule